// File: doc/BRIEF.md
# Gray-Scale Dilation/Erosion Window Unit

This block produces one gray-scale morphology result for each window of nine pixels it is given. Each window arrives in one cycle as nine pixel codes, nine structuring-element codes and a mode bit. In dilation mode every lane adds its structuring-element code to its pixel and the block keeps the largest of the nine sums. In erosion mode every lane subtracts its structuring-element code from its pixel and the block keeps the smallest of the nine differences.

Lane results saturate, so the output has the same width as a pixel. A sum that overflows becomes the all-ones code, and a difference that would go negative becomes zero. The extremum is found by a tree of compare-and-swap nodes. Each node is a single magnitude comparator that steers a two-way multiplexer, and the direction of the selection follows the mode that travels with the window. The circuits that build the window from image lines sit upstream of this unit.

The design is fully pipelined. It has one register stage for the lane arithmetic and one for each level of the reduction tree. It accepts a new window on every cycle, and each result appears after a fixed delay together with a valid flag.

Top module: `morph_window_unit`

## Requirements
- R1: With the mode bit low (dilation), the result is the maximum over all lanes of pixel plus structuring-element code.
- R2: With the mode bit high (erosion), the result is the minimum over all lanes of pixel minus structuring-element code.
- R3: A lane sum above 15 (the largest 4-bit code) is replaced by 15 before the maximum is taken.
- R4: A lane difference below zero is replaced by 0 before the minimum is taken.
- R5: `res_valid` is high exactly 5 clock cycles after the edge that samples `win_valid` high, and it is low in every cycle whose window slot 5 cycles earlier carried no window.
- R6: The mode bit is sampled on the same edge as its window. Back-to-back windows with different modes each get their own operation.
- R7: While `rst_n` is low, and afterwards until a new window has travelled the pipeline, `res_valid` stays low. Windows accepted before a reset never produce a result.
- R8: A new window can be accepted on every cycle, and consecutive windows give consecutive results in the order they were accepted.
- R9: Lane k occupies bits [4k+3:4k] of both `win_pix` and `win_se`. The result does not depend on which lane holds the extremum, and when lanes tie the result is the tied value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| win_valid | input | 1 | A window is presented this cycle |
| win_erode | input | 1 | Operation for this window: 0 dilation, 1 erosion |
| win_pix | input | 36 | Nine 4-bit pixel codes, lane k at bits [4k+3:4k] |
| win_se | input | 36 | Nine 4-bit structuring-element codes, same packing |
| res_valid | output | 1 | The result on `res_pix` belongs to a window |
| res_pix | output | 4 | Saturated maximum or minimum of the window |

## Verification
A window sampled on one rising edge passes through one lane register and four tree registers. Its result and its valid flag are therefore due after the fifth rising edge, and nothing before then is a result. The bench drives inputs on falling edges and samples outputs on falling edges. It reads vector k at the fifth falling edge after the one that drove it, and it expects `res_valid` low in every slot that no window filled. An isolated window is watched at every slot from 1 to 6 to pin the delay exactly. After a reset that lands while a window is in flight, the bench confirms that no stale result appears in the slot where it would have been due.

// File: rtl/morph_pkg.sv
// Shared types and helpers for the window morphology unit.
// Assumes tree levels are numbered from the lane side, starting at 0.
package morph_pkg;

    // Operation carried alongside every window through the pipeline.
    typedef enum logic {
        MODE_DILATE = 1'b0,
        MODE_ERODE  = 1'b1
    } morph_mode_e;

    // Number of values present at a given level of a pairwise reduction tree.
    function automatic int unsigned level_width(int unsigned taps, int unsigned lvl);
        return (taps + (32'd1 << lvl) - 32'd1) >> lvl;
    endfunction

endpackage

// File: rtl/morph_lane.sv
// One arithmetic lane: adds or subtracts the structuring-element code from
// the pixel code, saturating to the pixel range, and registers the result.
// Assumes unsigned codes; mode is sampled together with the operands.
module morph_lane
    import morph_pkg::*;
#(
    parameter int unsigned PIX_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  morph_mode_e       mode,
    input  logic [PIX_W-1:0]  pix,
    input  logic [PIX_W-1:0]  se,
    output logic [PIX_W-1:0]  lane_q
);

    localparam int unsigned      EXT_W    = PIX_W + 1;
    localparam logic [PIX_W-1:0] CODE_TOP = '1;

    logic [EXT_W-1:0] sum_ext;
    logic [PIX_W-1:0] sum_sat;
    logic [PIX_W-1:0] diff_sat;
    logic [PIX_W-1:0] lane_d;

    // Saturating add and subtract, then pick by mode.
    always_comb begin
        sum_ext  = {1'b0, pix} + {1'b0, se};
        sum_sat  = sum_ext[PIX_W] ? CODE_TOP : sum_ext[PIX_W-1:0];
        diff_sat = (se > pix) ? '0 : (pix - se);
        lane_d   = (mode == MODE_ERODE) ? diff_sat : sum_sat;
    end

    // Lane result register (arithmetic pipeline stage).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lane_q <= '0;
        end else begin
            lane_q <= lane_d;
        end
    end

endmodule

// File: rtl/morph_cas.sv
// Compare-and-swap node: one magnitude comparator steering one multiplexer.
// Keeps the larger input for dilation and the smaller for erosion.
// Assumes equal inputs may resolve to either side (same value).
module morph_cas
    import morph_pkg::*;
#(
    parameter int unsigned PIX_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  morph_mode_e       mode,
    input  logic [PIX_W-1:0]  side_a,
    input  logic [PIX_W-1:0]  side_b,
    output logic [PIX_W-1:0]  pick_q
);

    logic a_above_b;
    logic take_a;

    // Single comparator, direction folded into the select.
    always_comb begin
        a_above_b = side_a > side_b;
        take_a    = a_above_b ^ (mode == MODE_ERODE);
    end

    // Registered multiplexer output (one tree level).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pick_q <= '0;
        end else begin
            pick_q <= take_a ? side_a : side_b;
        end
    end

endmodule

// File: rtl/morph_tree.sv
// Pipelined reduction tree of compare-and-swap nodes, one register stage per
// level. An odd value left over at a level is delayed by a plain register so
// all paths keep equal latency. Valid and mode travel level by level.
// Assumes TAPS >= 2.
module morph_tree
    import morph_pkg::*;
#(
    parameter int unsigned PIX_W = 4,
    parameter int unsigned TAPS  = 9
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   in_valid,
    input  morph_mode_e            in_mode,
    input  logic [TAPS*PIX_W-1:0]  in_data,
    output logic                   out_valid,
    output logic [PIX_W-1:0]       out_data
);

    localparam int unsigned LEVELS = $clog2(TAPS);

    for (genvar l = 0; l < LEVELS; l++) begin : g_lvl
        localparam int unsigned CUR = level_width(TAPS, l);
        localparam int unsigned NXT = level_width(TAPS, l + 1);

        logic [CUR*PIX_W-1:0] cur_bus;
        logic [NXT*PIX_W-1:0] nxt_bus;
        logic                 cur_v;
        logic                 nxt_v;
        morph_mode_e          cur_m;

        if (l == 0) begin : g_head
            assign cur_bus = in_data;
            assign cur_v   = in_valid;
            assign cur_m   = in_mode;
        end else begin : g_link
            assign cur_bus = g_lvl[l-1].nxt_bus;
            assign cur_v   = g_lvl[l-1].nxt_v;
            assign cur_m   = g_lvl[l-1].g_mode.nxt_m;
        end

        // Valid flag for this level.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                nxt_v <= 1'b0;
            end else begin
                nxt_v <= cur_v;
            end
        end

        if (l < LEVELS - 1) begin : g_mode
            morph_mode_e nxt_m;
            // Mode follows its window into the next level.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    nxt_m <= MODE_DILATE;
                end else begin
                    nxt_m <= cur_m;
                end
            end
        end

        for (genvar i = 0; i < NXT; i++) begin : g_node
            logic [PIX_W-1:0] node_q;

            if (2 * i + 1 < CUR) begin : g_cas
                morph_cas #(
                    .PIX_W (PIX_W)
                ) u_cas (
                    .clk    (clk),
                    .rst_n  (rst_n),
                    .mode   (cur_m),
                    .side_a (cur_bus[(2*i)*PIX_W +: PIX_W]),
                    .side_b (cur_bus[(2*i+1)*PIX_W +: PIX_W]),
                    .pick_q (node_q)
                );
            end else begin : g_pass
                // Leftover value delayed one level.
                always_ff @(posedge clk) begin
                    if (!rst_n) begin
                        node_q <= '0;
                    end else begin
                        node_q <= cur_bus[(2*i)*PIX_W +: PIX_W];
                    end
                end
            end

            assign nxt_bus[i*PIX_W +: PIX_W] = node_q;
        end
    end

    assign out_valid = g_lvl[LEVELS-1].nxt_v;
    assign out_data  = g_lvl[LEVELS-1].nxt_bus;

endmodule

// File: rtl/morph_window_unit.sv
// Top of the gray-scale dilation/erosion window unit. Nine saturating lanes
// feed a compare-and-swap tree; latency is one lane stage plus one stage per
// tree level. Assumes lane k of each bus sits at bits [k*PIX_W +: PIX_W].
module morph_window_unit
    import morph_pkg::*;
#(
    parameter int unsigned PIX_W = 4,
    parameter int unsigned TAPS  = 9
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   win_valid,
    input  logic                   win_erode,
    input  logic [TAPS*PIX_W-1:0]  win_pix,
    input  logic [TAPS*PIX_W-1:0]  win_se,
    output logic                   res_valid,
    output logic [PIX_W-1:0]       res_pix
);

    localparam int unsigned BUS_W = TAPS * PIX_W;

    morph_mode_e           win_mode;
    morph_mode_e           lane_mode_q;
    logic                  lane_valid_q;
    logic [BUS_W-1:0]      lane_bus;

    assign win_mode = morph_mode_e'(win_erode);

    for (genvar k = 0; k < TAPS; k++) begin : g_lane
        morph_lane #(
            .PIX_W (PIX_W)
        ) u_lane (
            .clk    (clk),
            .rst_n  (rst_n),
            .mode   (win_mode),
            .pix    (win_pix[k*PIX_W +: PIX_W]),
            .se     (win_se[k*PIX_W +: PIX_W]),
            .lane_q (lane_bus[k*PIX_W +: PIX_W])
        );
    end

    // Valid and mode alongside the lane stage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lane_valid_q <= 1'b0;
            lane_mode_q  <= MODE_DILATE;
        end else begin
            lane_valid_q <= win_valid;
            lane_mode_q  <= win_mode;
        end
    end

    morph_tree #(
        .PIX_W (PIX_W),
        .TAPS  (TAPS)
    ) u_tree (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (lane_valid_q),
        .in_mode   (lane_mode_q),
        .in_data   (lane_bus),
        .out_valid (res_valid),
        .out_data  (res_pix)
    );

endmodule

// File: rtl/morph_window_chk.sv
// Checker for the window unit: keeps a delayed behavioural result and the
// delayed valid flag, and compares them with the ports. Bound to the top.
module morph_window_chk #(
    parameter int unsigned PIX_W = 4,
    parameter int unsigned TAPS  = 9
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   win_valid,
    input  logic                   win_erode,
    input  logic [TAPS*PIX_W-1:0]  win_pix,
    input  logic [TAPS*PIX_W-1:0]  win_se,
    input  logic                   res_valid,
    input  logic [PIX_W-1:0]       res_pix
);

    localparam int unsigned LAT = 1 + $clog2(TAPS);

    function automatic logic [PIX_W-1:0] model(input logic erode,
                                               input logic [TAPS*PIX_W-1:0] p,
                                               input logic [TAPS*PIX_W-1:0] s);
        logic [PIX_W-1:0] best;
        logic [PIX_W-1:0] v;
        logic [PIX_W-1:0] pk;
        logic [PIX_W-1:0] sk;
        logic [PIX_W:0]   acc;
        best = erode ? '1 : '0;
        for (int k = 0; k < TAPS; k++) begin
            pk  = p[k*PIX_W +: PIX_W];
            sk  = s[k*PIX_W +: PIX_W];
            acc = {1'b0, pk} + {1'b0, sk};
            if (erode) v = (sk > pk) ? '0 : (pk - sk);
            else       v = acc[PIX_W] ? '1 : acc[PIX_W-1:0];
            if (erode ? (v < best) : (v > best)) best = v;
        end
        return best;
    endfunction

    logic             hv [0:LAT-1];
    logic             hm [0:LAT-1];
    logic [PIX_W-1:0] hr [0:LAT-1];

    // Delay line of expected valid, mode and result.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < LAT; k++) begin
                hv[k] <= 1'b0;
                hm[k] <= 1'b0;
                hr[k] <= '0;
            end
        end else begin
            hv[0] <= win_valid;
            hm[0] <= win_erode;
            hr[0] <= model(win_erode, win_pix, win_se);
            for (int k = 1; k < LAT; k++) begin
                hv[k] <= hv[k-1];
                hm[k] <= hm[k-1];
                hr[k] <= hr[k-1];
            end
        end
    end

    AST_DILATE_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && !hm[LAT-1]) |-> (res_pix == hr[LAT-1])); // R1
    AST_ERODE_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && hm[LAT-1]) |-> (res_pix == hr[LAT-1])); // R2
    AST_FIXED_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid == hv[LAT-1]); // R5
    AST_RESET_QUIET: assert property (@(posedge clk)
        !rst_n |=> !res_valid); // R7

endmodule

bind morph_window_unit morph_window_chk #(
    .PIX_W (PIX_W),
    .TAPS  (TAPS)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .win_valid (win_valid),
    .win_erode (win_erode),
    .win_pix   (win_pix),
    .win_se    (win_se),
    .res_valid (res_valid),
    .res_pix   (res_pix)
);

// File: tb/morph_window_unit_tb.sv
`timescale 1ns/1ps
module morph_window_unit_tb;

    localparam int unsigned PIX_W = 4;
    localparam int unsigned TAPS  = 9;
    localparam int unsigned BUS_W = PIX_W * TAPS;
    localparam int unsigned LAT   = 5;
    localparam int unsigned NV    = 11;
    localparam int unsigned VEC_W = 1 + 2 * BUS_W + PIX_W;

    // {erode, pixels, structuring codes, expected}
    localparam logic [VEC_W-1:0] VEC [0:NV-1] = '{
        {1'b0, 36'h123456789, 36'h000000000, 4'h9},
        {1'b0, 36'h000000000, 36'h000000003, 4'h3},
        {1'b0, 36'h00000000E, 36'h000000005, 4'hF},
        {1'b1, 36'h123456789, 36'h000000000, 4'h1},
        {1'b1, 36'h333333333, 36'h555555555, 4'h0},
        {1'b1, 36'h888888888, 36'h012345670, 4'h1},
        {1'b0, 36'h000F00000, 36'h000100000, 4'hF},
        {1'b0, 36'h777777777, 36'h000000000, 4'h7},
        {1'b1, 36'hAAAAAAAAA, 36'h111111111, 4'h9},
        {1'b0, 36'h102030405, 36'h504030201, 4'h6},
        {1'b1, 36'h102030405, 36'h504030201, 4'h0}
    };

    logic             clk = 1'b0;
    logic             rst_n;
    logic             win_valid;
    logic             win_erode;
    logic [BUS_W-1:0] win_pix;
    logic [BUS_W-1:0] win_se;
    logic             res_valid;
    logic [PIX_W-1:0] res_pix;

    int errors = 0;
    int checks = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    morph_window_unit #(
        .PIX_W (PIX_W),
        .TAPS  (TAPS)
    ) u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .win_valid (win_valid),
        .win_erode (win_erode),
        .win_pix   (win_pix),
        .win_se    (win_se),
        .res_valid (res_valid),
        .res_pix   (res_pix)
    );

    function automatic string vec_tag(input int i);
        case (i)
            0, 1:    return "R1 R9";
            2, 6:    return "R3";
            3, 5:    return "R2 R6";
            4:       return "R4";
            7, 8:    return "R9";
            default: return "R8 R6";
        endcase
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic drive(input int i);
        win_valid = 1'b1;
        win_erode = VEC[i][VEC_W-1];
        win_pix   = VEC[i][VEC_W-2 -: BUS_W];
        win_se    = VEC[i][VEC_W-2-BUS_W -: BUS_W];
    endtask

    task automatic idle();
        win_valid = 1'b0;
        win_erode = 1'b0;
        win_pix   = '0;
        win_se    = '0;
    endtask

    initial begin
        #(20 * 20000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0;
        idle();
        repeat (3) @(negedge clk);
        check("R7 valid low in reset", {31'd0, res_valid}, 32'd0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R7 valid low after reset", {31'd0, res_valid}, 32'd0);

        // Isolated window: result due exactly LAT slots later (R5).
        drive(0);
        for (int d = 1; d <= LAT + 1; d++) begin
            @(negedge clk);
            check("R5 latency slot", {31'd0, res_valid}, (d == LAT) ? 32'd1 : 32'd0);
            if (d == LAT) check("R1 isolated result", {28'd0, res_pix}, 32'h9);
            idle();
        end

        // Back-to-back stream through the table (R8, R6 mixed modes).
        drive(0);
        for (int c = 1; c < NV + LAT + 2; c++) begin
            @(negedge clk);
            if (c >= LAT && c - LAT < NV) begin
                check({vec_tag(c - LAT), " valid"}, {31'd0, res_valid}, 32'd1);
                check({vec_tag(c - LAT), " result"}, {28'd0, res_pix},
                      {28'd0, VEC[c - LAT][PIX_W-1:0]});
            end else if (c >= LAT) begin
                check("R5 no window no valid", {31'd0, res_valid}, 32'd0);
            end
            if (c < NV) drive(c);
            else        idle();
        end

        // Reset while a window is in flight: no stale result (R7).
        drive(2);
        @(negedge clk);
        idle();
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        check("R7 valid low in mid reset", {31'd0, res_valid}, 32'd0);
        rst_n = 1'b1;
        for (int d = 0; d < LAT + 2; d++) begin
            @(negedge clk);
            check("R7 flushed window", {31'd0, res_valid}, 32'd0);
        end

        // Extremum in the top lane, erosion with a single low lane (R9, R2).
        win_valid = 1'b1;
        win_erode = 1'b1;
        win_pix   = 36'h2FFFFFFFF;
        win_se    = 36'h000000000;
        @(negedge clk);
        idle();
        repeat (LAT - 1) @(negedge clk);
        check("R9 top lane valid", {31'd0, res_valid}, 32'd1);
        check("R9 top lane minimum", {28'd0, res_pix}, 32'h2);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule